// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator with External Lock

This block is the direct digital synthesis core that produces the colour subcarrier phase for a video encoder. A 32-bit phase register advances by an increment on every pixel clock. The increment normally comes from four byte-wide frequency registers. A downstream sine/cosine table and the chroma modulator take the phase from here; they are not part of this block.

A single lock pin can keep the subcarrier aligned to an outside source, and a two-bit mode input selects what the pin does. In plain mode the pin is ignored. In phase-clear mode a rising edge on the pin arms a phase clear, and the clear is carried out at the next field start, not at the edge. In serial mode the pin carries a 67-bit word, two clocks per bit. Bits 0 to 21 of that word give a new frequency, which replaces the increment at the next line start, so the subcarrier follows line-length drift. When serial mode is used, software leaves the four frequency registers at zero. The field-start and line-start strobes come from the timing generator. A one-cycle `lock_upd` pulse marks each clear or increment load.

The serial receiver is a small state machine. `RX_WAIT_LOW` goes to `RX_ARMED` once the pin is sampled low. `RX_ARMED` goes to `RX_START` when the pin is sampled high, which is the first clock of the start cell. `RX_START` goes to `RX_DATA` on the next clock, which is the second clock of the start cell. `RX_DATA` counts 67 two-clock cells and samples each one on its second clock. After the last sample it returns to `RX_WAIT_LOW`, and it also returns there whenever serial mode is not selected.

Top module: `sc_phase_acc`

## Requirements
- R1: While `rst_n` is low and on the first clock after it, `phase_out` is 0 and `lock_upd` is 0. The frequency registers and the received increment reset to 0.
- R2: On each clock `phase_out` increases by the active increment, modulo 2^32. Outside serial mode the active increment is the frequency word. Byte select 0 writes bits 7:0 and select 3 writes bits 31:24, and a write first affects the step made on the clock after the write.
- R3: With mode 2'b00 or 2'b11 the lock pin has no effect: `phase_out` is never cleared and `lock_upd` stays 0.
- R4: With mode 2'b01 a 0-to-1 change on the lock pin arms a clear. On the next clock that samples `field_start` high, `phase_out` becomes 0 and `lock_upd` pulses for one cycle. Leaving mode 2'b01 drops an armed clear.
- R5: A rising edge that is sampled in the same clock as `field_start` does not clear the phase at that field start. It clears the phase at the following field start.
- R6: Serial word format in mode 2'b10. The pin must be sampled low before a start is accepted. A start cell of two high clocks follows. Then 67 bits come, bit 0 first, each held for two clocks and sampled on the second clock. Bits 0 to 21 form the frequency, and bits 22 to 66 have no effect.
- R7: In mode 2'b10 the active increment is the last received frequency shifted left by 10. A completed word is loaded at the next clock that samples `line_start` high, and `lock_upd` pulses for one cycle when it is loaded.
- R8: A word whose last bit is sampled in the same clock as `line_start` is not loaded by that line start. It is loaded at the next one.
- R9: A `line_start` with no completed word waiting leaves the increment unchanged and gives no `lock_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_wr_en | input | 1 | Write strobe for one frequency byte |
| freq_wr_sel | input | 2 | Byte select, 0 = least significant |
| freq_wr_data | input | 8 | Byte value to write |
| lock_mode | input | 2 | 00/11 plain, 01 phase clear, 10 serial |
| lock_pin | input | 1 | External lock pin |
| field_start | input | 1 | One-clock strobe at the start of each field |
| line_start | input | 1 | One-clock strobe at the start of each line |
| phase_out | output | 32 | Accumulator phase |
| lock_upd | output | 1 | Pulse when a clear or an increment load takes effect |

## Verification
In serial mode, two functions can fall in the same clock: the sample of the last bit of a word, and a `line_start`. The bench sends a word whose final bit cell ends on a line-start clock. It expects no `lock_upd` on that clock, then a load at the next line start. In phase-clear mode, the pin rising edge and a `field_start` can also coincide. The bench provokes this and expects the phase to keep running through that field start and to be cleared only at the next one. A per-cycle reference model feeds a queue of expected phase and strobe values, and each entry is compared against the outputs.

// File: rtl/sc_lock_pkg.sv
package sc_lock_pkg;
    typedef enum logic [1:0] {
        PIN_PLAIN   = 2'b00,
        PIN_CLEAR   = 2'b01,
        PIN_SERIAL  = 2'b10,
        PIN_PLAIN_B = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        RX_WAIT_LOW,
        RX_ARMED,
        RX_START,
        RX_DATA
    } rx_state_e;
endpackage

// File: rtl/sc_freq_regs.sv
module sc_freq_regs #(
    parameter int BYTES = 4,
    localparam int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [7:0]           wr_data,
    output logic [BYTES*8-1:0]   word
);
    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word[i*8 +: 8] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(i)) begin
                word[i*8 +: 8] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/sc_serial_rx.sv
module sc_serial_rx
    import sc_lock_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int FREQ_BITS = 22,
    parameter int WORD_BITS = 67,
    localparam int SHIFT    = ACC_W - FREQ_BITS,
    localparam int CNT_W    = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pin,
    input  logic             line_start,
    output logic [ACC_W-1:0] rtc_incr,
    output logic             load_strobe
);
    rx_state_e              state_q, state_d;
    logic                   half_q, half_d;
    logic [CNT_W-1:0]       bit_q, bit_d;
    logic                   sample, word_done;
    logic [FREQ_BITS-1:0]   shreg, held;
    logic                   held_v;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= RX_WAIT_LOW;
            half_q  <= 1'b0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
            bit_q   <= bit_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        half_d    = half_q;
        bit_d     = bit_q;
        sample    = 1'b0;
        word_done = 1'b0;
        unique case (state_q)
            RX_WAIT_LOW: if (!pin) state_d = RX_ARMED;
            RX_ARMED:    if (pin)  state_d = RX_START;
            RX_START: begin
                state_d = RX_DATA;
                half_d  = 1'b0;
                bit_d   = '0;
            end
            RX_DATA: begin
                half_d = ~half_q;
                if (half_q) begin
                    sample = 1'b1;
                    bit_d  = bit_q + 1'b1;
                    if (bit_q == CNT_W'(WORD_BITS - 1)) begin
                        word_done = 1'b1;
                        state_d   = RX_WAIT_LOW;
                    end
                end
            end
            default: state_d = RX_WAIT_LOW;
        endcase
    end

    for (genvar i = 0; i < FREQ_BITS; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shreg[i] <= 1'b0;
            end else if (sample && bit_q == CNT_W'(i)) begin
                shreg[i] <= pin;
            end
        end
    end

    logic [FREQ_BITS-1:0] cur_word;
    always_comb begin
        cur_word = shreg;
        if (bit_q == CNT_W'(FREQ_BITS - 1)) cur_word[FREQ_BITS-1] = pin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held        <= '0;
            held_v      <= 1'b0;
            rtc_incr    <= '0;
            load_strobe <= 1'b0;
        end else begin
            load_strobe <= 1'b0;
            if (enable && line_start && held_v) begin
                rtc_incr    <= {held, {SHIFT{1'b0}}};
                load_strobe <= 1'b1;
            end
            if (!enable) begin
                held_v <= 1'b0;
            end else if (word_done) begin
                held   <= (WORD_BITS == FREQ_BITS) ? cur_word : shreg;
                held_v <= 1'b1;
            end else if (line_start) begin
                held_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sc_phase_core.sv
module sc_phase_core #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] incr,
    input  logic             clr_enable,
    input  logic             pin,
    input  logic             field_start,
    output logic [ACC_W-1:0] phase,
    output logic             clr_strobe
);
    logic pin_q, pend;
    logic rise, apply;

    assign rise  = clr_enable && pin && !pin_q;
    assign apply = clr_enable && pend && field_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= '0;
            pin_q      <= 1'b1;
            pend       <= 1'b0;
            clr_strobe <= 1'b0;
        end else begin
            pin_q      <= pin;
            clr_strobe <= apply;
            phase      <= apply ? '0 : phase + incr;
            if (!clr_enable) pend <= 1'b0;
            else             pend <= (pend && !field_start) || rise;
        end
    end
endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc
    import sc_lock_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int FREQ_BITS = 22,
    parameter int WORD_BITS = 67,
    localparam int BYTES    = ACC_W / 8,
    localparam int SEL_W    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freq_wr_en,
    input  logic [SEL_W-1:0] freq_wr_sel,
    input  logic [7:0]       freq_wr_data,
    input  logic [1:0]       lock_mode,
    input  logic             lock_pin,
    input  logic             field_start,
    input  logic             line_start,
    output logic [ACC_W-1:0] phase_out,
    output logic             lock_upd
);
    pin_mode_e        mode;
    logic [ACC_W-1:0] freq_word, rtc_incr, incr;
    logic             load_strobe, clr_strobe;
    logic             serial_on, clear_on;

    assign mode      = pin_mode_e'(lock_mode);
    assign serial_on = (mode == PIN_SERIAL);
    assign clear_on  = (mode == PIN_CLEAR);
    assign incr      = serial_on ? rtc_incr : freq_word;
    assign lock_upd  = load_strobe | clr_strobe;

    sc_freq_regs #(.BYTES(BYTES)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(freq_wr_en), .wr_sel(freq_wr_sel),
        .wr_data(freq_wr_data), .word(freq_word)
    );

    sc_serial_rx #(.ACC_W(ACC_W), .FREQ_BITS(FREQ_BITS), .WORD_BITS(WORD_BITS)) i_rx (
        .clk(clk), .rst_n(rst_n), .enable(serial_on), .pin(lock_pin),
        .line_start(line_start), .rtc_incr(rtc_incr), .load_strobe(load_strobe)
    );

    sc_phase_core #(.ACC_W(ACC_W)) i_core (
        .clk(clk), .rst_n(rst_n), .incr(incr), .clr_enable(clear_on), .pin(lock_pin),
        .field_start(field_start), .phase(phase_out), .clr_strobe(clr_strobe)
    );
endmodule

// File: rtl/sc_phase_acc_chk.sv
module sc_phase_acc_chk #(
    parameter int ACC_W = 32,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             freq_wr_en,
    input logic [SEL_W-1:0] freq_wr_sel,
    input logic [1:0]       lock_mode,
    input logic             field_start,
    input logic             line_start,
    input logic [ACC_W-1:0] phase_out,
    input logic             lock_upd
);
    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (!rst_n)           seen <= '0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    // R3: a plain mode never produces an update
    p_plain_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && ($past(lock_mode) == 2'b00 || $past(lock_mode) == 2'b11)) |-> !lock_upd);

    // R4: an update in clear mode leaves the phase at zero after a field start
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && lock_upd && $past(lock_mode) == 2'b01) |-> (phase_out == '0 && $past(field_start)));

    // R4/R7: the update strobe lasts one cycle
    p_upd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_upd |=> !lock_upd);

    // R7: a serial-mode load follows a line start
    p_load_on_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && lock_upd && $past(lock_mode) == 2'b10) |-> $past(line_start));

    // R2: with nothing changing the increment, successive steps are equal
    p_even_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && !lock_upd && !$past(lock_upd) && !$past(lock_upd, 2)
         && !freq_wr_en && !$past(freq_wr_en) && !$past(freq_wr_en, 2)
         && $past(lock_mode) == lock_mode && $past(lock_mode, 2) == lock_mode)
        |-> (phase_out - $past(phase_out) == $past(phase_out) - $past(phase_out, 2)));
endmodule

bind sc_phase_acc sc_phase_acc_chk #(.ACC_W(ACC_W), .SEL_W(SEL_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .freq_wr_en(freq_wr_en), .freq_wr_sel(freq_wr_sel),
    .lock_mode(lock_mode), .field_start(field_start), .line_start(line_start),
    .phase_out(phase_out), .lock_upd(lock_upd)
);

// File: tb/test_sc_phase_acc.sv
module test_sc_phase_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freq_wr_en = 1'b0;
    logic [1:0]  freq_wr_sel = '0;
    logic [7:0]  freq_wr_data = '0;
    logic [1:0]  lock_mode = 2'b00;
    logic        lock_pin = 1'b0;
    logic        field_start = 1'b0;
    logic        line_start = 1'b0;
    logic [31:0] phase_out;
    logic        lock_upd;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    sc_phase_acc i_sc_phase_acc (
        .clk(clk), .rst_n(rst_n), .freq_wr_en(freq_wr_en), .freq_wr_sel(freq_wr_sel),
        .freq_wr_data(freq_wr_data), .lock_mode(lock_mode), .lock_pin(lock_pin),
        .field_start(field_start), .line_start(line_start),
        .phase_out(phase_out), .lock_upd(lock_upd)
    );

    // reference model and scoreboard
    logic [32:0] q_exp[$];
    string       q_tag[$];
    logic [31:0] m_freq, m_rtc, m_phase;
    logic [21:0] m_held, done_val;
    logic        m_held_v, m_pend, m_pin_prev, done_next = 1'b0;

    always @(posedge clk) begin
        logic [31:0] inc, nph;
        logic        upd;
        if (!rst_n) begin
            m_freq = '0; m_rtc = '0; m_phase = '0; m_held = '0;
            m_held_v = 1'b0; m_pend = 1'b0; m_pin_prev = 1'b1; done_next = 1'b0;
            q_exp.push_back(33'd0); q_tag.push_back("R1");
        end else begin
            inc = (lock_mode == 2'b10) ? m_rtc : m_freq;
            upd = 1'b0;
            if (lock_mode == 2'b01 && field_start && m_pend) begin
                nph = '0; upd = 1'b1;
            end else begin
                nph = m_phase + inc;
            end
            if (lock_mode != 2'b01) m_pend = 1'b0;
            else m_pend = (m_pend && !field_start) || (lock_pin && !m_pin_prev);
            if (lock_mode == 2'b10 && line_start && m_held_v) begin
                m_rtc = {m_held, 10'b0}; upd = 1'b1;
            end
            if (lock_mode != 2'b10) m_held_v = 1'b0;
            else if (done_next) begin m_held = done_val; m_held_v = 1'b1; end
            else if (line_start) m_held_v = 1'b0;
            done_next = 1'b0;
            if (freq_wr_en) m_freq[freq_wr_sel*8 +: 8] = freq_wr_data;
            m_pin_prev = lock_pin;
            m_phase = nph;
            q_exp.push_back({upd, nph}); q_tag.push_back(cur_tag);
        end
    end

    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [32:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if ({lock_upd, phase_out} !== e) begin
                errors++;
                $display("FAIL %s scoreboard: upd/phase got %b/%h expected %b/%h",
                         t, lock_upd, phase_out, e[32], e[31:0]);
            end
        end
    end

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_freq(input logic [31:0] w);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            freq_wr_en = 1'b1; freq_wr_sel = 2'(b); freq_wr_data = w[b*8 +: 8];
        end
        @(negedge clk);
        freq_wr_en = 1'b0;
    endtask

    task automatic pulse_field();
        @(negedge clk); field_start = 1'b1;
        @(negedge clk); field_start = 1'b0;
    endtask

    task automatic pulse_line();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
    endtask

    task automatic send_word(input logic [21:0] f, input logic [44:0] hi, input bit line_at_end);
        @(negedge clk); lock_pin = 1'b0;
        @(negedge clk); lock_pin = 1'b0;
        @(negedge clk); lock_pin = 1'b1;
        @(negedge clk); lock_pin = 1'b1;
        for (int k = 0; k < 67; k++) begin
            logic b;
            b = (k < 22) ? f[k] : hi[k-22];
            @(negedge clk); lock_pin = b;
            @(negedge clk); lock_pin = b;
            if (k == 66) begin
                done_val = f; done_next = 1'b1; line_start = line_at_end;
            end
        end
        @(negedge clk); lock_pin = 1'b0; line_start = 1'b0;
    endtask

    logic finished = 1'b0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] p0, p1;
        cycles(3);
        // R1 reset state
        check("R1", {lock_upd, phase_out}, 33'd0, "in reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", {lock_upd, phase_out}, 33'd0, "first cycle after reset");
        cycles(3);
        check("R1", {1'b0, phase_out}, 33'd0, "zero increment keeps phase");

        // R2 accumulation and byte order
        cur_tag = "R2";
        write_freq(32'h1234_5678);
        cycles(2);
        p0 = phase_out; @(negedge clk); p1 = phase_out;
        check("R2", {1'b0, p1 - p0}, {1'b0, 32'h1234_5678}, "step equals frequency word");
        write_freq(32'hF000_0001);
        cycles(40);
        p0 = phase_out; @(negedge clk); p1 = phase_out;
        check("R2", {1'b0, p1 - p0}, {1'b0, 32'hF000_0001}, "wrapping step");

        // R3 plain mode ignores pin
        cur_tag = "R3";
        @(negedge clk); lock_pin = 1'b1;
        pulse_field();
        check("R3", {31'd0, lock_upd, 1'b0}, 33'd0, "no update in plain mode");
        lock_mode = 2'b11;
        @(negedge clk); lock_pin = 1'b0;
        @(negedge clk); lock_pin = 1'b1;
        pulse_field();
        check("R3", {31'd0, lock_upd, 1'b0}, 33'd0, "no update in mode 11");
        lock_mode = 2'b00; lock_pin = 1'b0;
        cycles(2);

        // R4 clear deferred to next field start
        cur_tag = "R4";
        lock_mode = 2'b01;
        cycles(2);
        @(negedge clk); lock_pin = 1'b1;
        cycles(5);
        check("R4", {31'd0, lock_upd, 1'b0}, 33'd0, "no clear at the edge itself");
        pulse_field();
        check("R4", {lock_upd, phase_out}, {1'b1, 32'd0}, "clear at field start");
        @(negedge clk);
        check("R4", {1'b0, phase_out}, {1'b0, 32'hF000_0001}, "runs on after clear");
        pulse_field();
        check("R4", {31'd0, lock_upd, 1'b0}, 33'd0, "single clear per edge");

        // R5 edge together with field start
        cur_tag = "R5";
        @(negedge clk); lock_pin = 1'b0;
        @(negedge clk); lock_pin = 1'b1; field_start = 1'b1;
        @(negedge clk); field_start = 1'b0;
        check("R5", {31'd0, lock_upd, 1'b0}, 33'd0, "coincident edge not applied");
        cycles(4);
        pulse_field();
        check("R5", {lock_upd, phase_out}, {1'b1, 32'd0}, "applied at next field");
        lock_pin = 1'b0;

        // R6 / R7 serial word loaded at line start
        cur_tag = "R6";
        write_freq(32'h0);
        lock_mode = 2'b10;
        cycles(2);
        send_word(22'h2ABCDE, {45{1'b1}}, 1'b0);
        cur_tag = "R7";
        check("R7", {31'd0, lock_upd, 1'b0}, 33'd0, "no load before line start");
        pulse_line();
        check("R7", {31'd0, lock_upd, 1'b0}, {31'd0, 1'b1, 1'b0}, "load strobe");
        p0 = phase_out; @(negedge clk); p1 = phase_out;
        check("R6", {1'b0, p1 - p0}, {1'b0, 22'h2ABCDE, 10'b0}, "bits 0..21 shifted by 10");

        // R9 line start without new word
        cur_tag = "R9";
        pulse_line();
        check("R9", {31'd0, lock_upd, 1'b0}, 33'd0, "no update without word");
        p0 = phase_out; @(negedge clk); p1 = phase_out;
        check("R9", {1'b0, p1 - p0}, {1'b0, 22'h2ABCDE, 10'b0}, "increment kept");

        // R8 word end coincides with line start
        cur_tag = "R8";
        send_word(22'h15A5A5, 45'h0, 1'b1);
        check("R8", {31'd0, lock_upd, 1'b0}, 33'd0, "not loaded by coincident line start");
        cycles(3);
        pulse_line();
        check("R8", {31'd0, lock_upd, 1'b0}, {31'd0, 1'b1, 1'b0}, "loaded at next line start");
        p0 = phase_out; @(negedge clk); p1 = phase_out;
        check("R8", {1'b0, p1 - p0}, {1'b0, 22'h15A5A5, 10'b0}, "new increment");

        cycles(4);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule